// File: doc/BRIEF.md
# Write-Through Data Cache with Store Queue

This block is a small direct-mapped, write-through data cache that sits between a processor load/store port and a simple single-word memory port. Stores that hit a resident line update that line at once and are then queued in a shallow store queue, which writes them to memory in order in the background. Loads that hit are answered in the cycle they are presented, even while older stores are still waiting in the queue. Loads that miss first wait until the queue is empty and only then issue their memory read, so they always see every earlier store. A store that misses does not claim a line; it is only queued.

Every request carries an 8-bit space code that picks its treatment. Codes 0x08 to 0x0B are ordinary cached accesses. Code 0x01 and every code not listed here are uncached: loads always go to memory and never claim a line. Code 0x11 invalidates the whole cache, one line per cycle. Code 0x0E reads or writes the tag array directly, and code 0x0F reads or writes the data array directly. Addresses are word addresses: the low index bits select the line and the remaining bits form the tag.

The controller is a five-state machine. IDLE serves hits, stores and diagnostic accesses in one cycle. IDLE goes to WAIT_EMPTY on a load miss or an uncached load, and to SWEEP on a flush. WAIT_EMPTY goes to READ_MEM once the store queue is empty. READ_MEM goes to ANSWER when the memory acknowledges. SWEEP clears one line per cycle and goes to ANSWER after the last line. ANSWER completes the held request and always returns to IDLE.

Top module: `wt_dcache`

## Requirements
- R1: A load with a cached code (0x08 to 0x0B) that hits a valid line with a matching tag completes in the cycle it is presented, returning the line's word, even while the store queue still holds stores not yet written to memory.
- R2: A store with a cached or uncached code whose address hits a valid line writes its word into that line when it is accepted, so a following hitting load returns the new word with no wait.
- R3: A load that misses, or any load with an uncached code, waits until the store queue is empty, then issues one memory read and returns the memory word. No memory read is ever issued while a store is still queued.
- R4: A cached load miss fills its line with the tag and the word read from memory, so a repeated load of the same address then hits and completes with no wait.
- R5: Code 0x01 and every code other than 0x08-0x0B, 0x0E, 0x0F and 0x11 is uncached: its loads return the memory word even when a line holding other data is resident, and they leave the line as it was.
- R6: A store that misses does not allocate a line; a later cached load of the same address still misses.
- R7: A store is accepted only while the store queue has space; when it is full the store stalls until an entry drains. Queued stores reach memory in the order they were accepted.
- R8: Code 0x11 invalidates every line, takes one cycle per line plus one answer cycle (LINES+1 cycles of stall), and completes with a read word of zero.
- R9: Code 0x0E reads or writes the tag array at the line given by the address index bits. The word read has the valid flag in bit 31 and the tag in bits TAG_W-1:0, all other bits zero; a write takes the valid flag from bit 31 and the tag from bits TAG_W-1:0 of the write word.
- R10: Code 0x0F reads or writes the data word of the line given by the address index bits, completes in one cycle, and causes no memory transaction.
- R11: After reset every line is invalid, the store queue is empty, and neither the memory request nor the request-ready output is asserted while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held with its fields until req_ready |
| req_write | input | 1 | 1 for store, 0 for load |
| req_asi | input | 8 | Space code selecting the access treatment |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store word |
| req_ready | output | 1 | Request completes in this cycle |
| rsp_rdata | output | DATA_W | Load word, valid while req_ready is high for a load |
| mem_req | output | 1 | Memory transaction requested; held until mem_ack |
| mem_we | output | 1 | 1 for memory write, 0 for memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write word |
| mem_ack | input | 1 | Memory transaction done this cycle |
| mem_rdata | input | DATA_W | Memory read word, valid with mem_ack |

## Verification
The two functions that share a cycle are a hitting load being answered and the store queue writing an older store to memory, since the memory port and the hit path work independently. The bench slows the memory acknowledge to tens of cycles, queues stores to other lines, then presents a load that hits; the load must complete with zero wait cycles and the correct word while the queue is visibly still pending. In the other direction, a load that misses after those stores must find memory already holding every accepted store, which the memory model checks at each read.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [2:0] {
        AC_CACHED,
        AC_BYPASS,
        AC_FLUSH,
        AC_DIAG_TAG,
        AC_DIAG_DATA
    } acc_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_EMPTY,
        ST_READ_MEM,
        ST_ANSWER,
        ST_SWEEP
    } ctl_state_e;

    localparam logic [7:0] SPC_FLUSH     = 8'h11;
    localparam logic [7:0] SPC_DIAG_TAG  = 8'h0E;
    localparam logic [7:0] SPC_DIAG_DATA = 8'h0F;

    function automatic acc_class_e classify(input logic [7:0] spc);
        acc_class_e c;
        if (spc[7:2] == 6'b000010)    c = AC_CACHED;
        else if (spc == SPC_FLUSH)     c = AC_FLUSH;
        else if (spc == SPC_DIAG_TAG)  c = AC_DIAG_TAG;
        else if (spc == SPC_DIAG_DATA) c = AC_DIAG_DATA;
        else                           c = AC_BYPASS;
        return c;
    endfunction

endpackage

// File: rtl/wtc_store_queue.sv
module wtc_store_queue #(
    parameter int DEPTH  = 2,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              full,
    output logic              empty,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [PW-1:0]     rd_ptr;
    logic [PW-1:0]     wr_ptr;
    logic [CW-1:0]     count;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
    assign head_addr = addr_q[rd_ptr];
    assign head_data = data_q[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_addr;
            data_q[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7: the controller never pushes into a full queue
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R7: a drain acknowledge only arrives for a queued store
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/wtc_lines.sv
module wtc_lines #(
    parameter int LINES  = 8,
    parameter int TAG_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] idx,
    output logic                     rd_vld,
    output logic [TAG_W-1:0]         rd_tag,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     tag_we,
    input  logic                     wr_vld,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic                     data_we,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     clr_en,
    input  logic [$clog2(LINES)-1:0] clr_idx
);

    logic [LINES-1:0]  vld;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    assign rd_vld  = vld[idx];
    assign rd_tag  = tag_q[idx];
    assign rd_data = data_q[idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (clr_en) begin
            vld[clr_idx] <= 1'b0;
        end else if (tag_we) begin
            vld[idx] <= wr_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (tag_we)  tag_q[idx]  <= wr_tag;
        if (data_we) data_q[idx] <= wr_data;
    end

    // R8: a swept line reads back invalid on the following cycle
    assert_sweep_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !vld[$past(clr_idx)]);

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
    import wtc_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int LINES    = 8,
    parameter int WB_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_asi,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int IW    = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IW;

    ctl_state_e        state, state_nx;
    acc_class_e        cls;
    logic [IW-1:0]     idx;
    logic [TAG_W-1:0]  req_tag;
    logic [IW-1:0]     sweep_cnt;
    logic [DATA_W-1:0] answer_q;

    logic              rd_vld;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              hit;
    logic [DATA_W-1:0] diag_word;

    logic              tag_we, wr_vld, data_we, clr_en;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;

    logic              q_push, q_pop, q_full, q_empty;
    logic [ADDR_W-1:0] q_head_addr;
    logic [DATA_W-1:0] q_head_data;
    logic              fetch_req;

    assign cls     = classify(req_asi);
    assign idx     = req_addr[IW-1:0];
    assign req_tag = req_addr[ADDR_W-1:IW];
    assign hit     = rd_vld && (rd_tag == req_tag);

    always_comb begin
        diag_word              = '0;
        diag_word[TAG_W-1:0]   = rd_tag;
        diag_word[DATA_W-1]    = rd_vld;
    end

    wtc_lines #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (idx),
        .rd_vld  (rd_vld),
        .rd_tag  (rd_tag),
        .rd_data (rd_data),
        .tag_we  (tag_we),
        .wr_vld  (wr_vld),
        .wr_tag  (wr_tag),
        .data_we (data_we),
        .wr_data (wr_data),
        .clr_en  (clr_en),
        .clr_idx (sweep_cnt)
    );

    wtc_store_queue #(.DEPTH(WB_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_addr (req_addr),
        .push_data (req_wdata),
        .pop       (q_pop),
        .full      (q_full),
        .empty     (q_empty),
        .head_addr (q_head_addr),
        .head_data (q_head_data)
    );

    // Memory port: the read of a miss owns it; otherwise the queue drains
    assign mem_req   = fetch_req || !q_empty;
    assign mem_we    = !fetch_req;
    assign mem_addr  = fetch_req ? req_addr : q_head_addr;
    assign mem_wdata = q_head_data;
    assign q_pop     = mem_ack && !fetch_req;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sweep_cnt <= '0;
            answer_q  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_SWEEP) sweep_cnt <= sweep_cnt + 1'b1;
            else                   sweep_cnt <= '0;
            if (state == ST_READ_MEM && mem_ack)
                answer_q <= mem_rdata;
            else if (state == ST_IDLE && req_valid && cls == AC_FLUSH)
                answer_q <= '0;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx  = state;
        req_ready = 1'b0;
        rsp_rdata = answer_q;
        q_push    = 1'b0;
        tag_we    = 1'b0;
        wr_vld    = 1'b0;
        wr_tag    = req_tag;
        data_we   = 1'b0;
        wr_data   = req_wdata;
        clr_en    = 1'b0;
        fetch_req = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (cls)
                        AC_CACHED, AC_BYPASS: begin
                            if (req_write) begin
                                if (!q_full) begin
                                    req_ready = 1'b1;
                                    q_push    = 1'b1;
                                    data_we   = hit;
                                end
                            end else if (cls == AC_CACHED && hit) begin
                                req_ready = 1'b1;
                                rsp_rdata = rd_data;
                            end else begin
                                state_nx = ST_WAIT_EMPTY;
                            end
                        end
                        AC_FLUSH: state_nx = ST_SWEEP;
                        AC_DIAG_TAG: begin
                            req_ready = 1'b1;
                            rsp_rdata = diag_word;
                            tag_we    = req_write;
                            wr_vld    = req_wdata[DATA_W-1];
                            wr_tag    = req_wdata[TAG_W-1:0];
                        end
                        AC_DIAG_DATA: begin
                            req_ready = 1'b1;
                            rsp_rdata = rd_data;
                            data_we   = req_write;
                        end
                        default: state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_WAIT_EMPTY: begin
                if (q_empty) state_nx = ST_READ_MEM;
            end
            ST_READ_MEM: begin
                fetch_req = 1'b1;
                if (mem_ack) begin
                    state_nx = ST_ANSWER;
                    if (cls == AC_CACHED) begin
                        tag_we  = 1'b1;
                        wr_vld  = 1'b1;
                        data_we = 1'b1;
                        wr_data = mem_rdata;
                    end
                end
            end
            ST_ANSWER: begin
                req_ready = 1'b1;
                state_nx  = ST_IDLE;
            end
            ST_SWEEP: begin
                clr_en = 1'b1;
                if (sweep_cnt == IW'(LINES - 1)) state_nx = ST_ANSWER;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // R3: a memory read only leaves the block once every queued store is written
    assert_read_after_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> q_empty);

    // R3: the answer cycle lasts one cycle and returns to IDLE
    assert_answer_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ANSWER) |=> (state == ST_IDLE));

    // R3: a miss never completes while its memory read is outstanding
    assert_no_early_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ_MEM) |-> !req_ready);

    // R1: a hitting cached load in IDLE completes without stalling
    assert_hit_no_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid && !req_write && cls == AC_CACHED && hit)
        |=> (state == ST_IDLE));

    // R7: the memory request and its fields hold until acknowledged
    assert_mem_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

// File: tb/tb_wt_dcache.sv
`timescale 1ns/1ps
module tb_wt_dcache;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int LINES    = 8;
    localparam int WB_DEPTH = 2;
    localparam int IW       = 3;
    localparam int TAG_W    = ADDR_W - IW;
    localparam int MEMW     = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [7:0]        req_asi = 8'h00;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready;
    logic [DATA_W-1:0] rsp_rdata;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;

    wt_dcache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WB_DEPTH(WB_DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_asi(req_asi), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int mem_lat = 2;
    int st_acc = 0;
    int wr_done = 0;
    int rd_order_err = 0;
    int mem_tx = 0;
    bit finished = 0;

    logic [DATA_W-1:0] memarr [MEMW];
    logic [DATA_W-1:0] shadow [MEMW];
    logic              m_vld  [LINES];
    logic [TAG_W-1:0]  m_tag  [LINES];
    logic [DATA_W-1:0] m_data [LINES];

    task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] got,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // Memory responder: acknowledges after mem_lat cycles of request
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                cnt++;
                if (cnt >= mem_lat) begin
                    cnt = 0;
                    mem_ack = 1'b1;
                    mem_tx++;
                    if (mem_we) begin
                        memarr[mem_addr] = mem_wdata;
                        wr_done++;
                    end else begin
                        mem_rdata = memarr[mem_addr];
                        if (wr_done != st_acc) rd_order_err++;
                    end
                end
            end else begin
                cnt = 0;
            end
        end
    end

    // Expected-value functions from the requirements
    function automatic int cls_of(input logic [7:0] a);
        if (a >= 8'h08 && a <= 8'h0B) return 0;
        if (a == 8'h11) return 2;
        if (a == 8'h0E) return 3;
        if (a == 8'h0F) return 4;
        return 1;
    endfunction

    function automatic logic m_hit(input logic [ADDR_W-1:0] a);
        return m_vld[a[IW-1:0]] && (m_tag[a[IW-1:0]] == a[ADDR_W-1:IW]);
    endfunction

    // Predicts the read word and whether a load should hit, then updates the model
    task automatic model(input bit wr, input logic [7:0] asi, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] wd, output logic [DATA_W-1:0] exp,
                         output bit exp_hit);
        int c = cls_of(asi);
        logic [IW-1:0] i = a[IW-1:0];
        exp = '0;
        exp_hit = 0;
        if (c == 0 || c == 1) begin
            if (wr) begin
                if (m_hit(a)) m_data[i] = wd;
                shadow[a] = wd;
            end else if (c == 0 && m_hit(a)) begin
                exp = m_data[i];
                exp_hit = 1;
            end else begin
                exp = shadow[a];
                if (c == 0) begin
                    m_vld[i] = 1'b1;
                    m_tag[i] = a[ADDR_W-1:IW];
                    m_data[i] = shadow[a];
                end
            end
        end else if (c == 2) begin
            for (int k = 0; k < LINES; k++) m_vld[k] = 1'b0;
        end else if (c == 3) begin
            exp = '0;
            exp[TAG_W-1:0] = m_tag[i];
            exp[DATA_W-1] = m_vld[i];
            if (wr) begin
                m_vld[i] = wd[DATA_W-1];
                m_tag[i] = wd[TAG_W-1:0];
            end
        end else begin
            exp = m_data[i];
            if (wr) m_data[i] = wd;
        end
    endtask

    // One request; starts and ends just after a falling edge
    task automatic op(input bit wr, input logic [7:0] asi, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] wd, input string req,
                      output logic [DATA_W-1:0] rd, output int waits);
        logic [DATA_W-1:0] exp;
        bit exp_hit;
        int c = cls_of(asi);
        model(wr, asi, a, wd, exp, exp_hit);
        req_valid = 1'b1; req_write = wr; req_asi = asi; req_addr = a; req_wdata = wd;
        #1;
        waits = 0;
        while (!req_ready && waits < 2000) begin
            @(negedge clk); #1; waits++;
        end
        rd = rsp_rdata;
        @(negedge clk);
        req_valid = 1'b0;
        if ((c == 0 || c == 1) && wr) st_acc++;
        if (waits >= 2000) chk(0, {req, " timeout"}, DATA_W'(waits), '0);
        else if (!wr) chk(rd == exp, req, rd, exp);
        if (!wr && c == 0 && exp_hit) chk(waits == 0, "R1 hit wait", DATA_W'(waits), '0);
        if (!wr && (c == 1 || (c == 0 && !exp_hit)))
            chk(waits > 0, "R3 miss stalls", DATA_W'(waits), 1);
    endtask

    initial begin
        #150000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] rd;
        int w;
        int tx0;
        void'($urandom(32'd20240611));
        for (int k = 0; k < MEMW; k++) begin
            memarr[k] = 32'hA500_0000 ^ (k * 32'h0001_0203);
            shadow[k] = memarr[k];
        end
        for (int k = 0; k < LINES; k++) begin
            m_vld[k] = 1'b0; m_tag[k] = '0; m_data[k] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R11: reset state
        chk(mem_req == 1'b0, "R11 mem_req idle", DATA_W'(mem_req), 0);
        chk(req_ready == 1'b0, "R11 ready idle", DATA_W'(req_ready), 0);
        @(negedge clk);
        op(0, 8'h0E, 12'h003, 0, "R11 line invalid after reset", rd, w);

        // R4: cached miss allocates, repeat hits
        op(0, 8'h08, 12'h040, 0, "R4 first load", rd, w);
        op(0, 8'h09, 12'h040, 0, "R4 repeat load", rd, w);
        chk(w == 0, "R4 repeat hits", DATA_W'(w), 0);

        // R1: hit while a store is pending toward slow memory
        mem_lat = 40;
        op(1, 8'h01, 12'h081, 32'h1111_2222, "R1 store", rd, w);
        chk(st_acc - wr_done > 0, "R1 store pending", DATA_W'(st_acc - wr_done), 1);
        op(0, 8'h08, 12'h040, 0, "R1 hit during drain", rd, w);
        chk(w == 0, "R1 no wait", DATA_W'(w), 0);

        // R2: store hit updates line before memory
        op(1, 8'h0A, 12'h040, 32'hCAFE_0040, "R2 store hit", rd, w);
        op(0, 8'h08, 12'h040, 0, "R2 load new word", rd, w);
        chk(w == 0 && rd == 32'hCAFE_0040, "R2 new word no wait", rd, 32'hCAFE_0040);

        // R7: full queue stalls a store
        op(1, 8'h08, 12'h0C2, 32'h3333_4444, "R7 store full", rd, w);
        chk(w > 0, "R7 stall when full", DATA_W'(w), 1);

        // R3: miss drains first and sees the stored word
        op(0, 8'h01, 12'h081, 0, "R3 load after store", rd, w);
        chk(rd == 32'h1111_2222, "R3 stored word", rd, 32'h1111_2222);
        chk(rd_order_err == 0, "R3 read after drain", DATA_W'(rd_order_err), 0);
        mem_lat = 2;

        // R5: forced miss and unlisted code bypass a resident line
        op(1, 8'h0F, 12'h040, 32'hDEAD_BEEF, "R10 diag data write", rd, w);
        op(0, 8'h01, 12'h040, 0, "R5 forced miss reads memory", rd, w);
        op(0, 8'h30, 12'h040, 0, "R5 unlisted code reads memory", rd, w);
        op(0, 8'h08, 12'h040, 0, "R5 line left intact", rd, w);

        // R6: store miss does not allocate
        op(1, 8'h08, 12'h099, 32'h0606_0606, "R6 store miss", rd, w);
        op(0, 8'h08, 12'h099, 0, "R6 load still misses", rd, w);

        // R8: flush
        op(0, 8'h11, 12'h000, 0, "R8 flush word", rd, w);
        chk(w == LINES + 1, "R8 flush length", DATA_W'(w), DATA_W'(LINES + 1));
        op(0, 8'h0E, 12'h000, 0, "R8 line invalid", rd, w);
        op(0, 8'h0E, 12'h001, 0, "R8 line1 invalid", rd, w);
        op(0, 8'h08, 12'h040, 0, "R8 load misses after flush", rd, w);

        // R9 and R10: diagnostic tag and data writes
        tx0 = mem_tx;
        op(1, 8'h0F, 12'h005, 32'h5555_AAAA, "R10 diag data", rd, w);
        chk(w == 0, "R10 one cycle", DATA_W'(w), 0);
        op(1, 8'h0E, 12'h005, 32'h8000_0012, "R9 diag tag write", rd, w);
        op(0, 8'h0E, 12'h095, 0, "R9 diag tag read", rd, w);
        chk(rd == 32'h8000_0012, "R9 tag word format", rd, 32'h8000_0012);
        op(0, 8'h0F, 12'h005, 0, "R10 diag data read", rd, w);
        chk(mem_tx == tx0, "R10 no memory traffic", DATA_W'(mem_tx), DATA_W'(tx0));
        op(0, 8'h0B, 12'h095, 0, "R9 load hits written tag", rd, w);
        chk(rd == 32'h5555_AAAA, "R9 hit returns diag word", rd, 32'h5555_AAAA);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int r = int'($urandom % 16);
            logic [ADDR_W-1:0] a = ADDR_W'($urandom % 64);
            logic [DATA_W-1:0] d = $urandom;
            bit wr = ($urandom % 3) == 0;
            logic [7:0] asi;
            mem_lat = 1 + int'($urandom % 4);
            if (n % 50 == 25) mem_lat = 20;
            if (r < 6 || r > 11)      asi = 8'h08 + 8'($urandom % 4);
            else if (r == 6 || r == 7) asi = 8'h01;
            else if (r == 8)          asi = 8'h3C;
            else if (r == 9)          asi = 8'h0E;
            else if (r == 10)         asi = 8'h0F;
            else                      asi = (($urandom % 4) == 0) ? 8'h11 : 8'h08;
            if (asi == 8'h0E && wr) d = {d[31], 20'h0, 8'h0, 3'(d[2:0])};
            if (asi == 8'h0E && wr && ($urandom % 4) != 0) wr = 0;
            op(wr, asi, a, d, "R1 R2 R3 R5 random read", rd, w);
        end

        // R7: every accepted store reached memory in order
        mem_lat = 2;
        op(0, 8'h01, 12'h000, 0, "R7 final drain load", rd, w);
        for (int k = 0; k < 256; k++)
            chk(memarr[k] == shadow[k], "R7 memory image", memarr[k], shadow[k]);
        chk(rd_order_err == 0, "R3 all reads after drain", DATA_W'(rd_order_err), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule